// File: doc/BRIEF.md
# TAP Macro Shift Engine

This block drives the three output pins of a boundary-scan master (test clock, mode select and serial data out) for one vector operation. A nine-bit macro word supplies every mode-select value. Its low seven bits form a walk that is clocked out first. Bit 7 is the level held during looping phases. Bit 8 is the single exit value. After the walk, the macro kind selects what follows. A State macro may add one held bit and one exit bit. A BIST macro may idle for a programmed number of clocks with a default data level, then exit. Both shift kinds run, in this order, optional sync bits, an optional header taken from a parallel word, and the vector data.

The vector data arrives one bit at a time. The block asks for each bit with a one-cycle take strobe, so a memory or FIFO can feed it. During data bits the block raises a compare enable for a downstream comparator. For the shift-with-capture kind it also raises a capture enable and returns each sampled input bit with a valid pulse. The test clock runs at half the system clock. Outputs change only when the test clock falls, and the input is sampled when it rises. A start pulse loads the whole configuration from the input ports. A done pulse reports the end of the operation.

Top module: `jtag_macro_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, tck is 0, tms is 1, tdo is 0, and busy, done, capture_en, compare_en and cap_valid are 0.
- R2: While busy, tck alternates every system clock: 0 for one cycle, then 1 for one cycle. tms and tdo change only in the cycle in which tck goes low, or at the start edge, and never while tck is 1. While not busy, tck is 0.
- R3: Each operation begins with pre_len bits (0 to 7). The i-th bit has tms = mbits[i], and tdo keeps the value it had before.
- R4: With mkind = 0 (State), loop_en adds one bit with tms = mbits[7], and exit_en then adds one bit with tms = mbits[8]. tdo holds in both bits.
- R5: With mkind = 1 (BIST), loop_en adds bist_len bits with tms = mbits[7] and tdo = tdo_dflt. exit_en then adds one bit with tms = mbits[8] and tdo = tdo_dflt.
- R6: With mkind = 2 (Shift) or 3 (Shift with capture), sync_en adds sync_len bits with tdo = 1 and tms = mbits[7].
- R7: In the shift kinds, hdr_en then adds hdr_len bits (hdr_len at most 16). Header bit k carries hdr_data[k], least significant bit first, with tms = mbits[7].
- R8: In the shift kinds, vec_len data bits follow. Each takes data_in in the cycle data_take is high, which is exactly one pulse per data bit. The first vec_len-1 bits carry tms = mbits[7] and the last carries tms = mbits[8]. If vec_len is 0, there are no data bits and one exit bit follows with tms = mbits[8] and tdo held.
- R9: capture_en is 1 exactly during data bits of mkind 3. When tck rises during such a bit, cap_valid pulses with cap_bit equal to tdi at that edge. cap_valid is 0 otherwise.
- R10: compare_en is 1 exactly during data bits when cmp_en was set at start.
- R11: After the high phase of the last bit, busy falls and done pulses for one cycle. An operation with no bits pulses done without clocking tck. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| mkind | input | 2 | Macro kind: 0 State, 1 BIST, 2 Shift, 3 Shift with capture |
| mbits | input | 9 | Macro word: walk bits 6..0, loop bit 7, exit bit 8 |
| pre_len | input | 3 | Number of walk bits clocked first |
| loop_en | input | 1 | Enables the held bit (State) or the idle run (BIST) |
| exit_en | input | 1 | Enables the exit bit for State and BIST |
| bist_len | input | 16 | Clock count of the BIST idle run |
| tdo_dflt | input | 1 | Data level during the BIST run and exit |
| sync_en | input | 1 | Enables the sync bits |
| sync_len | input | 8 | Number of sync bits |
| hdr_en | input | 1 | Enables the header |
| hdr_len | input | 5 | Header length in bits |
| hdr_data | input | 16 | Header bits, least significant first |
| vec_len | input | 16 | Vector data length in bits |
| cmp_en | input | 1 | Compare mode for the data bits |
| data_in | input | 1 | Next vector data bit |
| data_take | output | 1 | data_in is consumed at this clock edge |
| tdi | input | 1 | Serial data returned from the scan chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdo | output | 1 | Serial data to the scan chain |
| capture_en | output | 1 | The current bit is a captured data bit |
| compare_en | output | 1 | The current bit is a compared data bit |
| cap_valid | output | 1 | cap_bit holds a newly sampled tdi |
| cap_bit | output | 1 | Sampled tdi |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions check the pin protocol on every cycle. tck stays low while idle and its high phase lasts one cycle. tms and tdo stay still while tck is high. Captured samples appear only on a rising test clock inside a capture bit. The enables and done agree with busy. The order of the phases is left to the bench's scenarios, as are the bit counts and the choice of mode-select and data values in each phase. So are the data level held across phases and operations, and the take strobe count. The bench compares these bit by bit against a model of the requirements.

// File: rtl/jme_pkg.sv
package jme_pkg;

    parameter int CNT_W    = 16;
    parameter int HDR_W    = 16;
    parameter int SYNC_W   = 8;
    parameter int PRE_W    = 3;
    parameter int MAC_W    = 9;
    parameter int LOOP_BIT = 7;
    parameter int EXIT_BIT = 8;
    localparam int HIDX_W  = $clog2(HDR_W + 1);
    localparam int NPH     = 7;

    typedef enum logic [1:0] {
        MK_STATE = 2'd0,
        MK_BIST  = 2'd1,
        MK_SHIFT = 2'd2,
        MK_SHCAP = 2'd3
    } mkind_e;

    // Phase order is the order in which bits leave the engine
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_MID  = 3'd2,
        PH_SYNC = 3'd3,
        PH_HDR  = 3'd4,
        PH_DATA = 3'd5,
        PH_FIN  = 3'd6
    } phase_e;

    typedef struct packed {
        mkind_e              kind;
        logic [MAC_W-1:0]    mbits;
        logic [PRE_W-1:0]    pre_len;
        logic                loop_en;
        logic                exit_en;
        logic [CNT_W-1:0]    bist_len;
        logic                tdo_dflt;
        logic                sync_en;
        logic [SYNC_W-1:0]   sync_len;
        logic                hdr_en;
        logic [HIDX_W-1:0]   hdr_len;
        logic [HDR_W-1:0]    hdr_data;
        logic [CNT_W-1:0]    vec_len;
        logic                cmp_en;
    } cfg_t;

    typedef struct packed {
        logic tms;
        logic drv;   // tdo takes val; otherwise tdo holds
        logic val;
        logic take;
        logic cap;
        logic cmp;
    } pin_bit_t;

    function automatic logic is_shift(mkind_e k);
        return k == MK_SHIFT || k == MK_SHCAP;
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(cfg_t c, phase_e p);
        logic [CNT_W-1:0] n;
        n = '0;
        case (p)
            PH_PRE:  n = CNT_W'(c.pre_len);
            PH_MID: begin
                if (c.kind == MK_STATE && c.loop_en)     n = CNT_W'(1);
                else if (c.kind == MK_BIST && c.loop_en) n = c.bist_len;
            end
            PH_SYNC: if (is_shift(c.kind) && c.sync_en) n = CNT_W'(c.sync_len);
            PH_HDR:  if (is_shift(c.kind) && c.hdr_en)  n = CNT_W'(c.hdr_len);
            PH_DATA: if (is_shift(c.kind) && c.vec_len != '0) n = c.vec_len - CNT_W'(1);
            PH_FIN:  if (is_shift(c.kind) || c.exit_en) n = CNT_W'(1);
            default: n = '0;
        endcase
        return n;
    endfunction

    function automatic pin_bit_t bit_of(cfg_t c, phase_e p, logic [CNT_W-1:0] idx,
                                        logic din);
        pin_bit_t         b;
        logic [MAC_W-1:0] msh;
        logic [HDR_W-1:0] hsh;
        msh = c.mbits >> idx[PRE_W-1:0];
        hsh = c.hdr_data >> idx;
        b   = '0;
        b.tms = c.mbits[LOOP_BIT];
        case (p)
            PH_PRE:  b.tms = msh[0];
            PH_MID: begin
                b.drv = (c.kind == MK_BIST);
                b.val = c.tdo_dflt;
            end
            PH_SYNC: begin
                b.drv = 1'b1;
                b.val = 1'b1;
            end
            PH_HDR: begin
                b.drv = 1'b1;
                b.val = hsh[0];
            end
            PH_DATA: begin
                b.drv  = 1'b1;
                b.val  = din;
                b.take = 1'b1;
                b.cap  = (c.kind == MK_SHCAP);
                b.cmp  = c.cmp_en;
            end
            PH_FIN: begin
                b.tms = c.mbits[EXIT_BIT];
                if (is_shift(c.kind)) begin
                    if (c.vec_len != '0) begin
                        b.drv  = 1'b1;
                        b.val  = din;
                        b.take = 1'b1;
                        b.cap  = (c.kind == MK_SHCAP);
                        b.cmp  = c.cmp_en;
                    end
                end else if (c.kind == MK_BIST) begin
                    b.drv = 1'b1;
                    b.val = c.tdo_dflt;
                end
            end
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/jme_tck_gen.sv
module jme_tck_gen (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic tck,
    output logic rise
);
    logic tck_q;

    assign rise = busy && !tck_q;
    assign tck  = tck_q;

    always_ff @(posedge clk) begin
        if (rst) tck_q <= 1'b0;
        else     tck_q <= rise;
    end
endmodule

// File: rtl/jme_phase_seq.sv
module jme_phase_seq
    import jme_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] plen [NPH],
    output phase_e           nxt_phase,
    output logic [CNT_W-1:0] nxt_idx,
    output logic             busy
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] nxt_cnt;
    phase_e           found;
    logic             stay;

    always_comb begin
        found = PH_IDLE;
        for (int p = NPH - 1; p >= 0; p--) begin
            if (p > int'(phase_q) && plen[p] != '0) found = phase_e'(3'(p));
        end
    end

    assign stay      = (phase_q != PH_IDLE) && (cnt_q > CNT_W'(1));
    assign nxt_phase = stay ? phase_q : found;
    assign nxt_idx   = stay ? idx_q + CNT_W'(1) : '0;
    assign nxt_cnt   = stay ? cnt_q - CNT_W'(1) : plen[found];
    assign busy      = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else if (load) begin
            phase_q <= nxt_phase;
            cnt_q   <= nxt_cnt;
            idx_q   <= nxt_idx;
        end
    end
endmodule

// File: rtl/jme_pin_drive.sv
module jme_pin_drive (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic ending,
    input  logic rise,
    input  logic b_tms,
    input  logic b_drv,
    input  logic b_val,
    input  logic b_cap,
    input  logic b_cmp,
    input  logic tdi,
    output logic tms,
    output logic tdo,
    output logic capture_en,
    output logic compare_en,
    output logic cap_valid,
    output logic cap_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tms        <= 1'b1;
            tdo        <= 1'b0;
            capture_en <= 1'b0;
            compare_en <= 1'b0;
        end else if (load) begin
            if (ending) begin
                capture_en <= 1'b0;
                compare_en <= 1'b0;
            end else begin
                tms        <= b_tms;
                capture_en <= b_cap;
                compare_en <= b_cmp;
                if (b_drv) tdo <= b_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_bit   <= 1'b0;
        end else begin
            cap_valid <= rise && capture_en;
            if (rise && capture_en) cap_bit <= tdi;
        end
    end
endmodule

// File: rtl/jtag_macro_engine.sv
module jtag_macro_engine
    import jme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mkind,
    input  logic [MAC_W-1:0]  mbits,
    input  logic [PRE_W-1:0]  pre_len,
    input  logic              loop_en,
    input  logic              exit_en,
    input  logic [CNT_W-1:0]  bist_len,
    input  logic              tdo_dflt,
    input  logic              sync_en,
    input  logic [SYNC_W-1:0] sync_len,
    input  logic              hdr_en,
    input  logic [HIDX_W-1:0] hdr_len,
    input  logic [HDR_W-1:0]  hdr_data,
    input  logic [CNT_W-1:0]  vec_len,
    input  logic              cmp_en,
    input  logic              data_in,
    output logic              data_take,
    input  logic              tdi,
    output logic              tck,
    output logic              tms,
    output logic              tdo,
    output logic              capture_en,
    output logic              compare_en,
    output logic              cap_valid,
    output logic              cap_bit,
    output logic              busy,
    output logic              done
);
    cfg_t             cfg_in, cfg_q, src;
    logic [CNT_W-1:0] plen [NPH];
    phase_e           nxt_phase;
    logic [CNT_W-1:0] nxt_idx;
    pin_bit_t         nb;
    logic             load, rise, ending;

    always_comb begin
        cfg_in.kind     = mkind_e'(mkind);
        cfg_in.mbits    = mbits;
        cfg_in.pre_len  = pre_len;
        cfg_in.loop_en  = loop_en;
        cfg_in.exit_en  = exit_en;
        cfg_in.bist_len = bist_len;
        cfg_in.tdo_dflt = tdo_dflt;
        cfg_in.sync_en  = sync_en;
        cfg_in.sync_len = sync_len;
        cfg_in.hdr_en   = hdr_en;
        cfg_in.hdr_len  = hdr_len;
        cfg_in.hdr_data = hdr_data;
        cfg_in.vec_len  = vec_len;
        cfg_in.cmp_en   = cmp_en;
    end

    // While idle the next bit is chosen from the live ports
    assign src = busy ? cfg_q : cfg_in;

    generate
        for (genvar g = 0; g < NPH; g++) begin : g_len
            assign plen[g] = phase_len(src, phase_e'(3'(g)));
        end
    endgenerate

    assign load      = busy ? tck : start;
    assign ending    = (nxt_phase == PH_IDLE);
    assign nb        = bit_of(src, nxt_phase, nxt_idx, data_in);
    assign data_take = load && !ending && nb.take;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            done  <= 1'b0;
        end else begin
            if (start && !busy) cfg_q <= cfg_in;
            done <= load && ending;
        end
    end

    jme_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .plen      (plen),
        .nxt_phase (nxt_phase),
        .nxt_idx   (nxt_idx),
        .busy      (busy)
    );

    jme_tck_gen u_tck (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .tck  (tck),
        .rise (rise)
    );

    jme_pin_drive u_pins (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .ending     (ending),
        .rise       (rise),
        .b_tms      (nb.tms),
        .b_drv      (nb.drv),
        .b_val      (nb.val),
        .b_cap      (nb.cap),
        .b_cmp      (nb.cmp),
        .tdi        (tdi),
        .tms        (tms),
        .tdo        (tdo),
        .capture_en (capture_en),
        .compare_en (compare_en),
        .cap_valid  (cap_valid),
        .cap_bit    (cap_bit)
    );
endmodule

// File: rtl/jme_chk.sv
module jme_chk (
    input logic clk,
    input logic rst,
    input logic tck,
    input logic tms,
    input logic tdo,
    input logic busy,
    input logic done,
    input logic capture_en,
    input logic compare_en,
    input logic cap_valid
);
    // R2
    idle_tck_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    // R2
    tck_high_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tck |=> !tck);

    // R2
    tck_low_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tck) |=> tck);

    // R2
    pins_still_high_chk: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdo)));

    // R9
    cap_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> (tck && capture_en));

    // R9
    capture_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        capture_en |-> busy);

    // R10
    compare_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        compare_en |-> busy);

    // R11
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind jtag_macro_engine jme_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tck        (tck),
    .tms        (tms),
    .tdo        (tdo),
    .busy       (busy),
    .done       (done),
    .capture_en (capture_en),
    .compare_en (compare_en),
    .cap_valid  (cap_valid)
);

// File: tb/jtag_macro_engine_bench.sv
`timescale 1ns/1ps
module jtag_macro_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mkind = '0;
    logic [8:0]  mbits = '0;
    logic [2:0]  pre_len = '0;
    logic        loop_en = 1'b0, exit_en = 1'b0;
    logic [15:0] bist_len = '0;
    logic        tdo_dflt = 1'b0;
    logic        sync_en = 1'b0;
    logic [7:0]  sync_len = '0;
    logic        hdr_en = 1'b0;
    logic [4:0]  hdr_len = '0;
    logic [15:0] hdr_data = '0;
    logic [15:0] vec_len = '0;
    logic        cmp_en = 1'b0;
    logic        data_in, data_take, tdi;
    logic        tck, tms, tdo, capture_en, compare_en, cap_valid, cap_bit, busy, done;

    logic [31:0] pat = 32'hA5C3_1E69;
    int          takes = 0;
    int          base = 0;
    int          checks = 0;
    int          fails = 0;

    typedef struct packed { logic tms; logic tdo; logic cap; logic cmp; } exp_t;
    exp_t        expq[$];
    logic        m_tdo = 1'b0;   // model of the held tdo level

    always #2.5 clk = ~clk;

    assign data_in = pat[(takes - base) & 31];
    assign tdi     = ~tdo;

    jtag_macro_engine u_jtag_macro_engine (
        .clk(clk), .rst(rst), .start(start), .mkind(mkind), .mbits(mbits),
        .pre_len(pre_len), .loop_en(loop_en), .exit_en(exit_en),
        .bist_len(bist_len), .tdo_dflt(tdo_dflt), .sync_en(sync_en),
        .sync_len(sync_len), .hdr_en(hdr_en), .hdr_len(hdr_len),
        .hdr_data(hdr_data), .vec_len(vec_len), .cmp_en(cmp_en),
        .data_in(data_in), .data_take(data_take), .tdi(tdi), .tck(tck),
        .tms(tms), .tdo(tdo), .capture_en(capture_en), .compare_en(compare_en),
        .cap_valid(cap_valid), .cap_bit(cap_bit), .busy(busy), .done(done)
    );

    always @(posedge clk) if (data_take) takes <= takes + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: one expected item per rising test clock
    logic prev_tck = 1'b0;
    int   cyc = 0, last_rise = -1;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!busy) last_rise = -1;
            if (tck && !prev_tck) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == 2, "R2", "tck period", cyc - last_rise, 2);
                last_rise = cyc;
                if (expq.size() == 0) begin
                    check(1'b0, "R11", "unexpected extra bit", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check({tms, tdo, capture_en, compare_en} == e, "R3-R10 bit",
                          "tms/tdo/cap/cmp", {tms, tdo, capture_en, compare_en}, e);
                    check(cap_valid == e.cap && (!e.cap || cap_bit == ~e.tdo), "R9",
                          "cap_valid/cap_bit", {cap_valid, cap_bit}, {e.cap, ~e.tdo});
                end
            end
            prev_tck = tck;
        end
    end

    function automatic void push(logic t, logic d, logic c, logic m);
        exp_t e;
        e.tms = t; e.tdo = d; e.cap = c; e.cmp = m;
        expq.push_back(e);
        m_tdo = d;
    endfunction

    // Driver: build the expected bits from the requirements, then start
    task automatic run_op(input string tag, input bit poke_busy);
        int n_take;
        n_take = 0;
        for (int i = 0; i < int'(pre_len); i++) push(mbits[i], m_tdo, 0, 0);
        if (mkind == 2'd0) begin
            if (loop_en) push(mbits[7], m_tdo, 0, 0);
            if (exit_en) push(mbits[8], m_tdo, 0, 0);
        end else if (mkind == 2'd1) begin
            if (loop_en) for (int i = 0; i < int'(bist_len); i++) push(mbits[7], tdo_dflt, 0, 0);
            if (exit_en) push(mbits[8], tdo_dflt, 0, 0);
        end else begin
            if (sync_en) for (int i = 0; i < int'(sync_len); i++) push(mbits[7], 1'b1, 0, 0);
            if (hdr_en) for (int i = 0; i < int'(hdr_len); i++) push(mbits[7], hdr_data[i], 0, 0);
            if (vec_len == 0) push(mbits[8], m_tdo, 0, 0);
            for (int i = 0; i < int'(vec_len); i++) begin
                push((i == int'(vec_len) - 1) ? mbits[8] : mbits[7], pat[i],
                     mkind == 2'd3, cmp_en);
                n_take++;
            end
        end
        @(negedge clk);
        base  = takes;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            pre_len = 3'd7;
            mkind   = 2'd1;
            start   = 1'b1;
            @(negedge clk);
            start   = 1'b0;
        end
        begin
            int waited;
            waited = 0;
            while (!done && waited < 3000) begin
                @(negedge clk);
                waited++;
            end
            check(done == 1'b1, "R11", {tag, " done pulse"}, done, 1);
        end
        check(busy == 1'b0, "R11", {tag, " busy after done"}, busy, 0);
        check(expq.size() == 0, "R11", {tag, " bits left"}, expq.size(), 0);
        check(takes - base == n_take, "R8", {tag, " data takes"}, takes - base, n_take);
        @(negedge clk);
        check(done == 1'b0, "R11", {tag, " done one cycle"}, done, 0);
        expq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({tck, tms, tdo, busy, done, capture_en, compare_en, cap_valid} == 8'b0100_0000,
              "R1", "pins in reset",
              {tck, tms, tdo, busy, done, capture_en, compare_en, cap_valid}, 8'b0100_0000);
        rst = 1'b0;
        @(negedge clk);
        check({tck, tms, tdo, busy, done} == 5'b01000, "R1", "pins after reset",
              {tck, tms, tdo, busy, done}, 5'b01000);

        // R3 R4: State with walk, loop and exit
        mkind = 2'd0; mbits = 9'b1_0_0101101; pre_len = 3'd5; loop_en = 1; exit_en = 1;
        run_op("R4 state", 0);
        // R4: exit only
        mbits = 9'b0_1_1111111; pre_len = 3'd0; loop_en = 0; exit_en = 1;
        run_op("R4 exit only", 0);
        // R5: BIST idle run with default high, then exit
        mkind = 2'd1; mbits = 9'b1_0_1110001; pre_len = 3'd3; loop_en = 1; exit_en = 1;
        bist_len = 16'd6; tdo_dflt = 1;
        run_op("R5 bist high", 0);
        // R5: exit only, default low
        loop_en = 0; tdo_dflt = 0; pre_len = 3'd7; mbits = 9'b1_1_0110010;
        run_op("R5 bist exit", 0);
        // R6 R7 R8 R10: shift with sync, header and compare
        mkind = 2'd2; mbits = 9'b1_0_0000011; pre_len = 3'd4; sync_en = 1; sync_len = 8'd3;
        hdr_en = 1; hdr_len = 5'd5; hdr_data = 16'h0015; vec_len = 16'd9; cmp_en = 1;
        run_op("R6 shift", 0);
        // R9: capture kind, data only
        mkind = 2'd3; sync_en = 0; hdr_en = 0; vec_len = 16'd12; cmp_en = 0; pre_len = 3'd2;
        run_op("R9 capture", 0);
        // R8: single data bit carries the exit value
        vec_len = 16'd1; cmp_en = 1; pat = 32'h0000_0001;
        run_op("R8 len one", 0);
        // R8: zero length, exit bit with tdo held
        mkind = 2'd2; vec_len = 16'd0; pre_len = 3'd1;
        run_op("R8 len zero", 0);
        // R8: data first, taken at the start edge
        pat = 32'h8000_0006; pre_len = 3'd0; vec_len = 16'd3; hdr_en = 1; hdr_len = 5'd16;
        hdr_data = 16'hBEEF;
        run_op("R7 full header", 0);
        hdr_en = 0;
        run_op("R8 data first", 0);
        // R11: start while busy is ignored
        mkind = 2'd0; pre_len = 3'd6; mbits = 9'b0_1_0011010; loop_en = 1; exit_en = 1;
        run_op("R11 busy start", 1);
        // R11: operation with no bits
        mkind = 2'd0; pre_len = 3'd0; loop_en = 0; exit_en = 0;
        run_op("R11 empty", 0);
        check(tck == 1'b0, "R2", "tck idle", tck, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule